// File: doc/BRIEF.md
# Selectable-Order Burst Address Counter

This block produces the address sequence for four-beat bursts in a synchronous burst memory. A start address is captured whenever either of two address strobes is high at a rising clock edge. One strobe serves the processor side and the other serves the controller side. After that, a two-bit beat counter steps once per clock edge at which the advance input is high. The full output address is built from the captured upper bits, which pass through unchanged, and two low bits taken from the counter. Those low bits follow one of two orders. Linear order wraps inside the aligned group of four. Interleaved order XORs the start bits with the beat count.

The order-select input is sampled together with the start address and held for the whole burst. Its low level, which is the level an undriven mode pin is assumed to settle to, selects interleaved order. Bursting is optional: a new start address may be loaded at every edge with no dead cycle. All outputs come straight from registers through a small amount of logic, so the address for a beat appears at the edge that captured its control inputs.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is applied, and until the first load after reset, `addr_o` and `beat_o` are all zeros.
- R2: At an edge where `strb_cpu_i` or `strb_ctl_i` is high, `addr_o` takes the value of `addr_i` and `beat_o` becomes 0. Either strobe alone, or both together, has this effect.
- R3: At an edge with no strobe and `adv_i` high, `beat_o` increases by one modulo 4, so beat 3 is followed by beat 0.
- R4: At an edge with no strobe and `adv_i` low, `addr_o` and `beat_o` keep their values.
- R5: With linear order, `addr_o[1:0]` equals (start[1:0] + `beat_o`) mod 4. For example, start 1 gives the sequence 1,2,3,0.
- R6: With interleaved order, `addr_o[1:0]` equals start[1:0] XOR `beat_o`. For example, start 2 gives the sequence 2,3,0,1.
- R7: When a strobe and `adv_i` are high at the same edge, the load wins: `beat_o` becomes 0 and the new address is output.
- R8: `order_i` is sampled only at a load edge, where 1 selects linear and 0 selects interleaved. Changing it during a burst has no effect on that burst.
- R9: Between loads, `addr_o[ADDR_W-1:2]` stays equal to the captured start address bits.
- R10: Loads at consecutive edges each take effect, with no lost cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strb_cpu_i | input | 1 | Processor-side load strobe |
| strb_ctl_i | input | 1 | Controller-side load strobe |
| adv_i | input | 1 | Step the burst by one beat |
| order_i | input | 1 | Burst order captured at load: 1 linear, 0 interleaved |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Beat index within the burst |

## Verification
A corrupted beat counter shows up at the very next edge as a wrong `beat_o` and a wrong `addr_o[1:0]`. Because the counter cycles through all four states, a stuck or miscounting bit is exposed within at most four advances. A wrongly held order bit or base register also reaches `addr_o` in the same cycle, for example as an XOR pattern where a wrapped sum was expected. The difference is visible only at beats where the two orders disagree, so bursts are started from every low start value that separates them. Mid-burst toggling of `order_i` and simultaneous strobe and advance are applied so that a register enabled by the wrong term diverges within one cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_INTERLEAVED = 1'b0,
    ORD_LINEAR      = 1'b1
  } burst_order_e;

  localparam int unsigned BEAT_W = 2;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_cpu_i,
  input  logic              strb_ctl_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              load_o,
  output logic [ADDR_W-1:0] base_o,
  output burst_order_e      order_o
);
  logic [ADDR_W-1:0] base_q, base_d;
  burst_order_e      order_q, order_d;
  logic              load_en;

  // Either strobe starts a burst.
  assign load_en = strb_cpu_i | strb_ctl_i;

  always_comb begin
    base_d  = base_q;
    order_d = order_q;
    if (load_en) begin
      base_d  = addr_i;
      order_d = burst_order_e'(order_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_INTERLEAVED;
    end else begin
      base_q  <= base_d;
      order_q <= order_d;
    end
  end

  assign load_o  = load_en;
  assign base_o  = base_q;
  assign order_o = order_q;

  // R8: the captured order is frozen between loads.
  assert_order_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(order_q));
  // R2: a strobe captures the external address.
  assert_base_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> base_q == $past(addr_i));
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] cnt_o
);
  logic [BEAT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = '0;
    else if (adv_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2 and R7: a load clears the count, even when advance is also high.
  assert_load_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == '0);
  // R3: an advance without a load steps the count by one, wrapping.
  assert_adv_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_i) |=> cnt_q == BEAT_W'($past(cnt_q) + 1'b1));
  // R4: with no load and no advance, the count holds.
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(cnt_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int unsigned BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] cnt_i,
  input  burst_order_e      order_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  // Linear order: the sum wraps naturally at BEAT_W bits.
  assign lin_lo = start_i + cnt_i;

  // Interleaved order: a bitwise XOR of start and count.
  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_lo[b] = start_i[b] ^ cnt_i[b];
  end

  assign low_o = (order_i == ORD_LINEAR) ? lin_lo : ilv_lo;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_cpu_i,
  input  logic              strb_ctl_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              rst_sync_n;
  logic              load;
  logic [ADDR_W-1:0] base;
  burst_order_e      order_q;
  logic [BEAT_W-1:0] cnt;
  logic [BEAT_W-1:0] low;

  burst_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  burst_load_ctrl #(.ADDR_W(ADDR_W)) u_load (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .strb_cpu_i (strb_cpu_i),
    .strb_ctl_i (strb_ctl_i),
    .order_i    (order_i),
    .addr_i     (addr_i),
    .load_o     (load),
    .base_o     (base),
    .order_o    (order_q)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (load),
    .adv_i  (adv_i),
    .cnt_o  (cnt)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i (base[BEAT_W-1:0]),
    .cnt_i   (cnt),
    .order_i (order_q),
    .low_o   (low)
  );

  assign addr_o = {base[ADDR_W-1:BEAT_W], low};
  assign beat_o = cnt;

  // R9: upper address bits stay fixed between loads.
  assert_upper_stable_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !load |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
  // R2: the first beat after a load presents the external address exactly.
  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> addr_o == $past(addr_i));
  // R4: idle cycles leave the whole address unchanged.
  assert_idle_addr_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load && !adv_i) |=> $stable(addr_o));

  if (HI_W < 1) begin : g_width_check
    initial $error("ADDR_W must exceed the beat width");
  end
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int ADDR_W = 20;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [1:0]        beat;
    string             tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strb_cpu = 1'b0, strb_ctl = 1'b0, adv = 1'b0, order = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [ADDR_W-1:0] addr_out;
  logic [1:0]        beat_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  exp_t q[$];

  // Reference model state
  logic [ADDR_W-1:0] m_base = '0;
  logic [1:0]        m_cnt = '0;
  logic              m_lin = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_burst_addr_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_cpu_i (strb_cpu),
    .strb_ctl_i (strb_ctl),
    .adv_i      (adv),
    .order_i    (order),
    .addr_i     (addr_in),
    .addr_o     (addr_out),
    .beat_o     (beat_out)
  );

  function automatic logic [ADDR_W-1:0] model_addr();
    logic [1:0] lo;
    lo = m_lin ? 2'(m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
    return {m_base[ADDR_W-1:2], lo};
  endfunction

  task automatic check(string tag, logic [ADDR_W-1:0] ea, logic [1:0] eb);
    total++;
    if (addr_out !== ea || beat_out !== eb) begin
      bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_out, beat_out, ea, eb);
    end
  endtask

  task automatic drive(bit c, bit k, bit a, bit o, logic [ADDR_W-1:0] ad, string tag);
    exp_t e;
    @(negedge clk);
    strb_cpu = c; strb_ctl = k; adv = a; order = o; addr_in = ad;
    if (c || k) begin
      m_base = ad; m_cnt = 2'd0; m_lin = o;
    end else if (a) begin
      m_cnt = m_cnt + 2'd1;
    end
    e.addr = model_addr();
    e.beat = m_cnt;
    e.tag  = tag;
    q.push_back(e);
  endtask

  // Monitor: compare a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, e.addr, e.beat);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 2'd0);
    rst_n = 1'b1;
    // idle after release: outputs remain at zero
    drive(0, 0, 0, 0, '0, "R1 idle");
    drive(0, 0, 0, 0, '0, "R1 idle");
    drive(0, 0, 0, 0, '0, "R1 idle");

    // linear from start 1 via processor strobe: 1,2,3,0 then wrap to 1
    drive(1, 0, 0, 1, 20'hABCD1, "R2 cpu load");
    drive(0, 0, 1, 1, 20'h00000, "R5 lin b1");
    drive(0, 0, 1, 0, 20'h11111, "R8 lin b2 order toggled");
    drive(0, 0, 1, 0, 20'h22222, "R5 lin b3");
    drive(0, 0, 1, 1, 20'h33333, "R3 wrap to 0");
    drive(0, 0, 0, 1, 20'h44444, "R4 hold");
    drive(0, 0, 0, 0, 20'h55555, "R9 hold upper");

    // interleaved from start 2 via controller strobe: 2,3,0,1
    drive(0, 1, 0, 0, 20'h5A5A2, "R2 ctl load");
    drive(0, 0, 1, 1, 20'h0, "R6 ilv b1");
    drive(0, 0, 1, 1, 20'h0, "R6 ilv b2");
    drive(0, 0, 1, 0, 20'h0, "R6 ilv b3");
    drive(0, 0, 1, 0, 20'h0, "R9 upper through wrap");

    // linear from 3 vs interleaved from 3
    drive(1, 1, 0, 1, 20'hFFFF3, "R2 both strobes");
    drive(0, 0, 1, 0, 20'h0, "R5 lin 3 b1");
    drive(0, 0, 1, 0, 20'h0, "R5 lin 3 b2");
    drive(0, 1, 1, 0, 20'h12343, "R7 load beats advance");
    drive(0, 0, 1, 1, 20'h0, "R6 ilv 3 b1");
    drive(0, 0, 1, 1, 20'h0, "R6 ilv 3 b2");

    // back-to-back loads every edge
    drive(1, 0, 1, 1, 20'h00010, "R10 b2b 1");
    drive(0, 1, 0, 0, 20'h00021, "R10 b2b 2");
    drive(1, 0, 1, 1, 20'h00032, "R10 b2b 3");
    drive(0, 1, 1, 0, 20'h00043, "R10 b2b 4");
    drive(0, 0, 1, 0, 20'h0, "R6 after b2b");
    drive(0, 0, 0, 0, 20'h0, "R4 final hold");

    @(negedge clk);
    strb_cpu = 0; strb_ctl = 0; adv = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule